// File: doc/BRIEF.md
# Circular Peripheral-to-Memory DMA Channel

This block is one DMA channel that copies 16-bit samples from a fixed peripheral data register into a memory buffer, one item per peripheral request. Software programs an item count, a memory base address, a peripheral address and a configuration word, then sets the enable bit. Every accepted request produces an acknowledge pulse toward the peripheral and one single-beat write on the memory port, in the same cycle.

In circular mode, the channel goes back to the base address and reloads the full count after the last item, with no help from software. Two sticky status flags mark the buffer's midpoint and its end. Software can therefore work on one half of a single contiguous buffer while the other half fills. In one-shot mode the channel stops when the count reaches zero.

Top module: `circ_p2m_dma`

## Requirements
- R1: After reset every register reads zero, and `periph_ack` and `mem_we` are low.
- R2: The configuration register is at offset 0. Bit 0 enables the channel, bit 4 is the direction bit (0 = peripheral to memory), bit 5 selects circular mode, bit 7 enables memory-address increment, bits 9:8 hold the peripheral item size and bits 11:10 hold the memory item size (code 01 = 16 bits). All of these bits read back as written, and every other bit reads 0.
- R3: The channel accepts a request when it is enabled, the direction bit is 0, the remaining count is nonzero, `periph_req` is high and `periph_ack` is low. One cycle after acceptance, `periph_ack` and `mem_we` pulse together. `mem_wdata` then holds the `periph_rdata` value sampled at the accepting edge. `periph_addr` always equals the programmed peripheral address (offset 2).
- R4: With increment on, the write address starts at the memory base (offset 3) and rises by 2 per item. With increment off, every write goes to the same address.
- R5: Writing offset 1 sets the item count. Reading offset 1 returns the number of items still to move in the current pass, which drops by one per item.
- R6: The flag register is at offset 4. Bit 1 (half) sets when the remaining count reaches the programmed count divided by two, rounded down. Bit 0 (complete) sets when the remaining count reaches zero.
- R7: In circular mode the item after the last one restarts at the base address, and the remaining count reloads to the programmed count.
- R8: In one-shot mode the channel stops at a remaining count of zero, and later requests are not acknowledged.
- R9: Both flags stay set until software writes a 1 to the matching bit of the flag-clear register at offset 5 (bit 0 complete, bit 1 half). Writing 0 has no effect, and a new flag event in the same cycle as a clear wins.
- R10: While the channel is enabled, writes to the count, peripheral-address and memory-address registers are ignored.
- R11: No request is accepted while the channel is disabled or the direction bit is set. A request held high is accepted at most every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| periph_req | input | 1 | Peripheral has a sample ready |
| periph_ack | output | 1 | Sample taken, one-cycle pulse |
| periph_addr | output | 32 | Programmed peripheral data address |
| periph_rdata | input | 16 | Peripheral sample value |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address of the write |
| mem_wdata | output | 16 | Memory write data |

## Verification
The assertions assume that the peripheral drops `periph_req` in the cycle after it sees `periph_ack`, or else accepts being served every other cycle. They also assume that register writes to the count and address registers arrive only while the channel is disabled. The bench drives requests as single-cycle pulses with idle gaps, plus one deliberately held request. It issues its reconfiguration writes after clearing the enable bit, except for the writes meant to test that locked registers ignore writes. All inputs change on the falling edge, so each accepting edge sees stable request and data values.

// File: rtl/dma_chan_pkg.sv
// Package: register offsets, configuration bit positions and the decoded
// configuration type shared by the DMA channel modules.
package dma_chan_pkg;

    localparam logic [2:0] OFS_CFG   = 3'd0;
    localparam logic [2:0] OFS_CNT   = 3'd1;
    localparam logic [2:0] OFS_PADDR = 3'd2;
    localparam logic [2:0] OFS_MADDR = 3'd3;
    localparam logic [2:0] OFS_FLAGS = 3'd4;
    localparam logic [2:0] OFS_FCLR  = 3'd5;

    localparam int BIT_EN   = 0;
    localparam int BIT_DIR  = 4;
    localparam int BIT_CIRC = 5;
    localparam int BIT_MINC = 7;
    localparam int BIT_PSZ  = 8;
    localparam int BIT_MSZ  = 10;

    localparam int FLG_DONE = 0;
    localparam int FLG_HALF = 1;

    typedef struct packed {
        logic [1:0] msize;
        logic [1:0] psize;
        logic       minc;
        logic       circ;
        logic       dir;
        logic       en;
    } chan_cfg_t;

endpackage

// File: rtl/dma_cfg_regs.sv
// Module: dma_cfg_regs
// Holds the channel's programmable registers and the two sticky status flags.
// Assumes: count and address registers may only change while the channel is
// disabled; a flag event and a clear in the same cycle leave the flag set.
module dma_cfg_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              ev_half,
    input  logic              ev_done,
    output chan_cfg_t         cfg,
    output logic [CNT_W-1:0]  total_cnt,
    output logic [ADDR_W-1:0] paddr,
    output logic [ADDR_W-1:0] mbase,
    output logic              cnt_load,
    output logic              maddr_load,
    output logic              flag_half,
    output logic              flag_done
);

    logic cfg_wr, paddr_wr, fclr_wr;

    // Decode which register a write targets; locked ones need the channel off.
    always_comb begin
        cfg_wr     = reg_we && (reg_addr == OFS_CFG);
        cnt_load   = reg_we && (reg_addr == OFS_CNT)   && !cfg.en;
        paddr_wr   = reg_we && (reg_addr == OFS_PADDR) && !cfg.en;
        maddr_load = reg_we && (reg_addr == OFS_MADDR) && !cfg.en;
        fclr_wr    = reg_we && (reg_addr == OFS_FCLR);
    end

    // Store configuration, count and addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg       <= '0;
            total_cnt <= '0;
            paddr     <= '0;
            mbase     <= '0;
        end else begin
            if (cfg_wr) begin
                cfg.en    <= reg_wdata[BIT_EN];
                cfg.dir   <= reg_wdata[BIT_DIR];
                cfg.circ  <= reg_wdata[BIT_CIRC];
                cfg.minc  <= reg_wdata[BIT_MINC];
                cfg.psize <= reg_wdata[BIT_PSZ +: 2];
                cfg.msize <= reg_wdata[BIT_MSZ +: 2];
            end
            if (cnt_load)   total_cnt <= reg_wdata[CNT_W-1:0];
            if (paddr_wr)   paddr     <= reg_wdata[ADDR_W-1:0];
            if (maddr_load) mbase     <= reg_wdata[ADDR_W-1:0];
        end
    end

    // Sticky flags: events set, write-one clears, set wins on a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_half <= 1'b0;
            flag_done <= 1'b0;
        end else begin
            if (ev_half)                            flag_half <= 1'b1;
            else if (fclr_wr && reg_wdata[FLG_HALF]) flag_half <= 1'b0;
            if (ev_done)                            flag_done <= 1'b1;
            else if (fclr_wr && reg_wdata[FLG_DONE]) flag_done <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_xfer_engine.sv
// Module: dma_xfer_engine
// Accepts peripheral requests, tracks the remaining count and memory pointer,
// and issues one memory write per accepted item.
// Assumes: count/pointer loads and transfers never coincide (loads need the
// channel disabled, transfers need it enabled).
module dma_xfer_engine #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dir,
    input  logic              circ,
    input  logic              minc,
    input  logic [CNT_W-1:0]  total_cnt,
    input  logic [ADDR_W-1:0] mbase,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  cnt_load_val,
    input  logic              maddr_load,
    input  logic [ADDR_W-1:0] maddr_load_val,
    input  logic              periph_req,
    input  logic [DATA_W-1:0] periph_rdata,
    output logic              periph_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [CNT_W-1:0]  remaining,
    output logic              ev_half,
    output logic              ev_done
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    logic              accept;
    logic [CNT_W-1:0]  rem_dec;
    logic [ADDR_W-1:0] ptr;

    // Decide acceptance and the midpoint/end events for this item.
    always_comb begin
        accept  = en && !dir && (remaining != '0) && periph_req && !periph_ack;
        rem_dec = remaining - CNT_W'(1);
        ev_half = accept && (rem_dec == (total_cnt >> 1));
        ev_done = accept && (rem_dec == '0);
    end

    // Advance count and pointer, wrapping in circular mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            ptr       <= '0;
        end else begin
            if (cnt_load)
                remaining <= cnt_load_val;
            else if (accept)
                remaining <= (ev_done && circ) ? total_cnt : rem_dec;
            if (maddr_load)
                ptr <= maddr_load_val;
            else if (accept)
                ptr <= (ev_done && circ) ? mbase : (minc ? ptr + STEP : ptr);
        end
    end

    // Register the handshake and the memory write beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periph_ack <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
        end else begin
            periph_ack <= accept;
            mem_we     <= accept;
            if (accept) begin
                mem_addr  <= ptr;
                mem_wdata <= periph_rdata;
            end
        end
    end

endmodule

// File: rtl/circ_p2m_dma.sv
// Module: circ_p2m_dma
// One circular peripheral-to-memory DMA channel: register file, sticky flags
// and transfer engine, with a combinational register read mux.
// Assumes: ADDR_W <= 32; items are DATA_W bits wide.
module circ_p2m_dma
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic [ADDR_W-1:0] periph_addr,
    input  logic [DATA_W-1:0] periph_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    chan_cfg_t         cfg_q;
    logic [CNT_W-1:0]  total_cnt, remaining;
    logic [ADDR_W-1:0] mbase;
    logic              cnt_load, maddr_load, ev_half, ev_done;
    logic              flag_half, flag_done;
    logic              chan_en;

    assign chan_en = cfg_q.en;

    dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ev_half(ev_half), .ev_done(ev_done),
        .cfg(cfg_q), .total_cnt(total_cnt), .paddr(periph_addr), .mbase(mbase),
        .cnt_load(cnt_load), .maddr_load(maddr_load),
        .flag_half(flag_half), .flag_done(flag_done)
    );

    dma_xfer_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .dir(cfg_q.dir),
        .circ(cfg_q.circ), .minc(cfg_q.minc), .total_cnt(total_cnt),
        .mbase(mbase), .cnt_load(cnt_load), .cnt_load_val(reg_wdata[CNT_W-1:0]),
        .maddr_load(maddr_load), .maddr_load_val(reg_wdata[ADDR_W-1:0]),
        .periph_req(periph_req), .periph_rdata(periph_rdata),
        .periph_ack(periph_ack), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .remaining(remaining),
        .ev_half(ev_half), .ev_done(ev_done)
    );

    // Select the register image addressed by reg_addr.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CFG: begin
                reg_rdata[BIT_EN]        = cfg_q.en;
                reg_rdata[BIT_DIR]       = cfg_q.dir;
                reg_rdata[BIT_CIRC]      = cfg_q.circ;
                reg_rdata[BIT_MINC]      = cfg_q.minc;
                reg_rdata[BIT_PSZ +: 2]  = cfg_q.psize;
                reg_rdata[BIT_MSZ +: 2]  = cfg_q.msize;
            end
            OFS_CNT:   reg_rdata = 32'(remaining);
            OFS_PADDR: reg_rdata = 32'(periph_addr);
            OFS_MADDR: reg_rdata = 32'(mbase);
            OFS_FLAGS: begin
                reg_rdata[FLG_DONE] = flag_done;
                reg_rdata[FLG_HALF] = flag_half;
            end
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_checker.sv
// Module: dma_chan_checker
// Temporal checks on the channel's handshake, data path and count, attached
// to circ_p2m_dma by bind.
module dma_chan_checker #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              periph_req,
    input logic              periph_ack,
    input logic [DATA_W-1:0] periph_rdata,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [CNT_W-1:0]  remaining,
    input logic              chan_en
);

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> $past(periph_req)); // R3

    AST_WDATA_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == $past(periph_rdata))); // R3

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> !periph_ack); // R11

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !periph_ack); // R11

    AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining == '0) |=> !periph_ack); // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ($past(remaining) > CNT_W'(1))) |->
            (remaining == $past(remaining) - CNT_W'(1))); // R5

endmodule

bind circ_p2m_dma dma_chan_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .periph_ack(periph_ack),
    .periph_rdata(periph_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .remaining(remaining), .chan_en(chan_en)
);

// File: tb/circ_p2m_dma_bench.sv
// Bench: behavioural reference model compared on every cycle, plus directed
// checks for the requirement corner cases.
module circ_p2m_dma_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        periph_req = 1'b0;
    logic        periph_ack;
    logic [31:0] periph_addr;
    logic [15:0] periph_rdata = '0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;

    int errors = 0;
    int checks = 0;
    int ack_total = 0;
    logic [31:0] last_waddr = '0;

    always #10 clk = ~clk;

    circ_p2m_dma u_circ_p2m_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
        .periph_ack(periph_ack), .periph_addr(periph_addr),
        .periph_rdata(periph_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    // Reference model state
    logic [31:0] m_cfg, m_paddr, m_base, m_ptr, m_oaddr;
    int          m_total, m_rem;
    logic [15:0] m_odata;
    logic        m_ack, m_half, m_done;

    always @(posedge clk) begin
        logic acc, wrap, eh, ed;
        if (!rst_n) begin
            m_cfg = 0; m_paddr = 0; m_base = 0; m_ptr = 0; m_oaddr = 0;
            m_total = 0; m_rem = 0; m_odata = 0; m_ack = 0; m_half = 0; m_done = 0;
        end else begin
            acc = m_cfg[0] && !m_cfg[4] && m_rem != 0 && periph_req && !m_ack;
            eh = 0; ed = 0;
            if (acc) begin
                m_oaddr = m_ptr;
                m_odata = periph_rdata;
                m_rem   = m_rem - 1;
                eh = (m_rem == m_total / 2);
                ed = (m_rem == 0);
                wrap = ed && m_cfg[5];
                if (wrap) begin m_rem = m_total; m_ptr = m_base; end
                else if (m_cfg[7]) m_ptr = m_ptr + 2;
            end
            if (reg_we) begin
                case (reg_addr)
                    3'd1: if (!m_cfg[0]) begin m_total = reg_wdata[15:0]; m_rem = m_total; end
                    3'd2: if (!m_cfg[0]) m_paddr = reg_wdata;
                    3'd3: if (!m_cfg[0]) begin m_base = reg_wdata; m_ptr = reg_wdata; end
                    3'd5: begin
                        if (reg_wdata[0] && !ed) m_done = 0;
                        if (reg_wdata[1] && !eh) m_half = 0;
                    end
                    default: ;
                endcase
                if (reg_addr == 3'd0) m_cfg = reg_wdata & 32'hFB1;
            end
            if (eh) m_half = 1;
            if (ed) m_done = 1;
            m_ack = acc;
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cfg;
            3'd1: return 32'(m_rem);
            3'd2: return m_paddr;
            3'd3: return m_base;
            3'd4: return {30'd0, m_half, m_done};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R5";
            3'd4: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            check("R3 ack", 32'(periph_ack), 32'(m_ack));
            check("R3 we", 32'(mem_we), 32'(m_ack));
            check("R3 wdata", 32'(mem_wdata), 32'(m_odata));
            check("R3 paddr", periph_addr, m_paddr);
            check("R4 waddr", mem_addr, m_oaddr);
            check(read_tag(reg_addr), reg_rdata, model_read(reg_addr));
            if (periph_ack) ack_total++;
            if (mem_we) last_waddr = mem_addr;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk); reg_addr = a;
        #6 check(tag, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [15:0] d);
        @(negedge clk); periph_req = 1'b1; periph_rdata = d;
        @(negedge clk); periph_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic run;
        int a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 6; i++) rd("R1 reset", 3'(i), 32'd0);
        @(negedge clk); #6 check("R1 ack idle", 32'(periph_ack), 32'd0);

        wr(3'd1, 32'd8);
        wr(3'd2, 32'h4001_244C);
        wr(3'd3, 32'h2000_0100);
        wr(3'd0, 32'h0000_5A1);
        rd("R2 cfg readback", 3'd0, 32'h5A1);
        for (int i = 0; i < 4; i++) pulse(16'h0100 + 16'(i));
        rd("R5 remaining 4", 3'd1, 32'd4);
        rd("R6 half set", 3'd4, 32'd2);
        check("R4 increment", last_waddr, 32'h2000_0106);

        // R10: locked registers while enabled
        wr(3'd2, 32'h1234_5678);
        wr(3'd1, 32'd3);
        wr(3'd3, 32'h3000_0000);
        rd("R10 paddr locked", 3'd2, 32'h4001_244C);
        rd("R10 count locked", 3'd1, 32'd4);
        rd("R10 maddr locked", 3'd3, 32'h2000_0100);

        wr(3'd5, 32'd2);
        rd("R9 half cleared", 3'd4, 32'd0);
        for (int i = 0; i < 4; i++) pulse(16'hA000 + 16'(i));
        rd("R7 count reloaded", 3'd1, 32'd8);
        rd("R6 complete set", 3'd4, 32'd1);
        wr(3'd5, 32'd0);
        rd("R9 zero write no effect", 3'd4, 32'd1);
        wr(3'd5, 32'd1);
        rd("R9 complete cleared", 3'd4, 32'd0);
        pulse(16'hBEEF);
        check("R7 wrap to base", last_waddr, 32'h2000_0100);
        rd("R7 count after wrap", 3'd1, 32'd7);

        // R11: disabled and wrong direction
        wr(3'd0, 32'd0);
        a0 = ack_total;
        pulse(16'h1111);
        wr(3'd0, 32'h11);
        rd("R2 dir readback", 3'd0, 32'h11);
        pulse(16'h2222);
        check("R11 no ack when off or dir set", 32'(ack_total), 32'(a0));

        // R8: one-shot, no increment
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd2);
        wr(3'd3, 32'h2000_0200);
        wr(3'd5, 32'd3);
        wr(3'd0, 32'h501);
        a0 = ack_total;
        for (int i = 0; i < 3; i++) pulse(16'h5000 + 16'(i));
        check("R8 stops after count", 32'(ack_total - a0), 32'd2);
        rd("R8 count zero", 3'd1, 32'd0);
        rd("R6 both flags", 3'd4, 32'd3);
        check("R4 fixed address", last_waddr, 32'h2000_0200);

        // R11: held request served every other cycle
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd8);
        wr(3'd0, 32'h5A1);
        a0 = ack_total;
        @(negedge clk); periph_req = 1'b1; periph_rdata = 16'h7777;
        repeat (4) @(negedge clk);
        periph_req = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 held request", 32'(ack_total - a0), 32'd2);
        rd("R5 count after held", 3'd1, 32'd6);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule